// File: doc/BRIEF.md
# Multi-Link Synchronization Pulse Generator

This block is shared by several serial audio links. From the free-running oscillator clock it derives a periodic sync point, nominally 4 kHz, by reloading a down-counter from a programmable period. The period is set from the oscillator frequency alone: the rate in kHz divided by 4, minus one. That gives 5999 for a 24 MHz oscillator and 9599 for 38.4 MHz. The bus clock and frame rate play no part in it.

The same sync point is used to make bank switches on several links happen in one cycle. Software arms each participating link with a read-modify-write of its arm bit. It then writes the release bit. The block takes a snapshot of the armed set and clears the visible arm bits at once. At the next sync point it strobes every link in the snapshot in a single cycle, then drops the release bit, so software can poll for zero.

A handshake bit lets software learn when the sync timing has been handed to hardware. Software sets the bit. The block clears it at the first sync point after any link reports itself active.

Top module: `sync_pulse_gen`

## Requirements
- R1: While reset is asserted, `sync_pt` and `bank_sw` are 0. After reset, `reg_rdata` reads `RESET_PERIOD` in bits 14:0 and 0 in every other bit.
- R2: `sync_pt` is high for exactly one cycle every P+1 cycles, where P is the period field (bits 14:0).
- R3: A new period written to bits 14:0 does not cut the countdown in progress. It takes effect at the next reload, which happens on a `sync_pt` cycle.
- R4: A write that does not set the release bit (bit 24) stores bits 14:0 as the period and bits 19:16 as the per-link arm bits, with bit 16+i belonging to link i. `reg_rdata` returns these fields in the same positions.
- R5: A write with bit 24 set clears all arm bits, so they read 0 on the following cycle. The release bit then reads 1 until the release is performed.
- R6: After a release write, the first `sync_pt` cycle drives `bank_sw` with exactly the arm bits carried in that write. All the selected links are strobed in the same cycle as `sync_pt`.
- R7: The release bit reads 0 on the cycle after the sync point that performs the release. A release written with no arm bits set clears in the same way and produces no `bank_sw` strobe.
- R8: Once set, the handshake bit (bit 15) clears on the first sync point at or after any `link_active` input has been high. This holds even if that input has fallen again before the sync point.
- R9: The handshake bit is set only by writing 1 to bit 15. Writing 0 to bit 15 does not clear it, and it stays set across sync points while no link is active.
- R10: `bank_sw` is 0 in every cycle other than a release sync point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the sync register |
| reg_wdata | input | 32 | Write data for the sync register |
| reg_rdata | output | 32 | Current register value: release in bit 24, arm bits in 19:16, handshake in bit 15, period in 14:0 |
| link_active | input | NUM_LINKS | High while the corresponding link is active |
| sync_pt | output | 1 | One-cycle sync point strobe |
| bank_sw | output | NUM_LINKS | Per-link bank-switch strobes |

## Verification
The hardest case to reach is a handshake clear caused by a link that went active and then inactive again between two sync points. If the bench only holds `link_active` high, a design that samples the input just at the sync point would still look correct. The bench therefore pulses one link for a single cycle well away from a sync point. It confirms the bit is still set before the next sync point and cleared just after it. The release path is driven with several arm patterns and with an empty set. Every cycle between the release write and the sync point is watched for a stray strobe.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned PERIOD_LSB = 0;
  localparam int unsigned PERIOD_W   = 15;
  localparam int unsigned HS_BIT     = 15;
  localparam int unsigned ARM_LSB    = 16;
  localparam int unsigned ARM_SLOTS  = 4;
  localparam int unsigned GO_BIT     = 24;
endpackage

// File: rtl/sync_rst_sync.sv
module sync_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sync_period_counter.sv
module sync_period_counter #(
  parameter int unsigned PW           = 15,
  parameter int unsigned RESET_PERIOD = 5999
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_period,
  output logic [PW-1:0] period,
  output logic          sync_pt
);
  localparam logic [PW-1:0] RST_VAL = PW'(RESET_PERIOD);

  logic [PW-1:0] period_q, period_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  // next state: reload on zero with the period held before this edge
  always_comb begin
    period_d = period_q;
    if (wr_en) period_d = wr_period;
    if (at_zero) cnt_d = period_q;
    else         cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= RST_VAL;
      cnt_q    <= RST_VAL;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
    end
  end

  assign period  = period_q;
  assign sync_pt = at_zero;
endmodule

// File: rtl/sync_handshake.sv
module sync_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic link_any,
  input  logic sync_pt,
  output logic hs
);
  logic hs_q, hs_d;
  logic seen_q, seen_d;

  always_comb begin
    hs_d   = hs_q;
    seen_d = seen_q;
    if (hs_q) begin
      if (sync_pt && (seen_q || link_any)) begin
        hs_d   = 1'b0;
        seen_d = 1'b0;
      end else if (link_any) begin
        seen_d = 1'b1;
      end
    end
    if (set_req && !hs_q) begin
      hs_d   = 1'b1;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      hs_q   <= hs_d;
      seen_q <= seen_d;
    end
  end

  assign hs = hs_q;
endmodule

// File: rtl/sync_bank_switch.sv
module sync_bank_switch #(
  parameter int unsigned NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_go,
  input  logic [NL-1:0] wr_arm,
  input  logic          sync_pt,
  output logic [NL-1:0] arm,
  output logic          go,
  output logic [NL-1:0] bank_sw
);
  logic [NL-1:0] arm_q, arm_d;
  logic [NL-1:0] pend_q, pend_d;
  logic          go_q, go_d;
  logic          fire;

  assign fire = sync_pt && go_q;

  always_comb begin
    arm_d  = arm_q;
    pend_d = pend_q;
    go_d   = go_q;
    if (fire) begin
      go_d   = 1'b0;
      pend_d = '0;
    end
    if (wr_en) begin
      if (wr_go) begin
        arm_d  = '0;
        go_d   = 1'b1;
        pend_d = wr_arm;
      end else begin
        arm_d = wr_arm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      pend_q <= '0;
      go_q   <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      pend_q <= pend_d;
      go_q   <= go_d;
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_strobe
    assign bank_sw[i] = fire & pend_q[i];
  end

  assign arm = arm_q;
  assign go  = go_q;
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen #(
  parameter int unsigned NUM_LINKS    = 4,
  parameter int unsigned RESET_PERIOD = 5999
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINKS-1:0] link_active,
  output logic                 sync_pt,
  output logic [NUM_LINKS-1:0] bank_sw
);
  import sync_pkg::*;

  logic                 rst_n_sync;
  logic [PERIOD_W-1:0]  period;
  logic                 hs;
  logic                 go;
  logic [NUM_LINKS-1:0] arm;
  logic [ARM_SLOTS-1:0] arm_rd;
  logic                 unused_wbits;

  sync_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sync_period_counter #(.PW(PERIOD_W), .RESET_PERIOD(RESET_PERIOD)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (reg_wr),
    .wr_period (reg_wdata[PERIOD_LSB +: PERIOD_W]),
    .period    (period),
    .sync_pt   (sync_pt)
  );

  sync_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .set_req  (reg_wr && reg_wdata[HS_BIT]),
    .link_any (|link_active),
    .sync_pt  (sync_pt),
    .hs       (hs)
  );

  sync_bank_switch #(.NL(NUM_LINKS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (reg_wr),
    .wr_go   (reg_wdata[GO_BIT]),
    .wr_arm  (reg_wdata[ARM_LSB +: NUM_LINKS]),
    .sync_pt (sync_pt),
    .arm     (arm),
    .go      (go),
    .bank_sw (bank_sw)
  );

  if (NUM_LINKS < ARM_SLOTS) begin : g_arm_pad
    assign arm_rd = {{(ARM_SLOTS-NUM_LINKS){1'b0}}, arm};
  end else begin : g_arm_full
    assign arm_rd = arm;
  end

  // bit 24 release, 19:16 arm, 15 handshake, 14:0 period
  assign reg_rdata = {7'b0, go, 4'b0, arm_rd, hs, period};

  assign unused_wbits = ^{reg_wdata[31:25], reg_wdata[23:20]};
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk #(
  parameter int unsigned NUM_LINKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic                 sync_pt,
  input logic [NUM_LINKS-1:0] bank_sw
);
  a_r2_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pt && reg_rdata[14:0] != 15'd0) |=> !sync_pt);

  a_r5_arm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[24]) |=> (reg_rdata[19:16] == 4'd0 && reg_rdata[24]));

  a_r10_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_sw) |-> (sync_pt && reg_rdata[24]));

  a_r7_go_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pt && reg_rdata[24] && !(reg_wr && reg_wdata[24])) |=> !reg_rdata[24]);

  a_r9_hs_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[15]) |-> $past(reg_wr && reg_wdata[15]));

  a_r8_hs_clear_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[15]) |-> $past(sync_pt));
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .sync_pt   (sync_pt),
  .bank_sw   (bank_sw)
);

// File: tb/tb_sync_pulse_gen.sv
`timescale 1ns/1ps
module tb_sync_pulse_gen;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  link_active;
  logic        sync_pt;
  logic [3:0]  bank_sw;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  localparam logic [31:0] PER9 = 32'd9;

  sync_pulse_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .link_active (link_active),
    .sync_pt     (sync_pt),
    .bank_sw     (bank_sw)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_pt);
  endtask

  task automatic measure_gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sync_pt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_wdata = '0;
    link_active = '0;
    repeat (3) @(negedge clk);
    chk(sync_pt == 1'b0 && bank_sw == 4'd0, "R1 strobes in reset", {bank_sw, sync_pt}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(reg_rdata == 32'd5999, "R1 reset readback", reg_rdata, 5999);
  endtask

  task automatic t_default_period();
    int g;
    wait_sync();
    @(negedge clk);
    chk(sync_pt == 1'b0, "R2 one-cycle strobe", sync_pt, 0);
    wait_sync();
    measure_gap(g);
    chk(g == 6000, "R2 default gap", g, 6000);
  endtask

  task automatic t_period_change();
    int g;
    wait_sync();
    wr(PER9);
    g = 1;
    while (!sync_pt) begin @(negedge clk); g++; end
    chk(g == 6000, "R3 countdown kept", g, 6000);
    measure_gap(g);
    chk(g == 10, "R3 new period", g, 10);
    measure_gap(g);
    chk(g == 10, "R2 gap period 9", g, 10);
  endtask

  task automatic t_fields();
    wr(PER9 | 32'h000A_0000);
    chk(reg_rdata == 32'h000A_0009, "R4 arm 1010", reg_rdata, 32'h000A_0009);
    wr(PER9 | 32'h0005_0000);
    chk(reg_rdata == 32'h0005_0009, "R4 arm 0101", reg_rdata, 32'h0005_0009);
    wr(32'd0);
  endtask

  task automatic t_release(input logic [3:0] arm);
    int bad;
    bit hit;
    bad = 0;
    hit = 1'b0;
    wr(PER9 | {12'd0, arm, 16'd0});
    chk(reg_rdata[19:16] == arm, "R4 arm write", reg_rdata[19:16], arm);
    wr(PER9 | 32'h0100_0000 | {12'd0, arm, 16'd0});
    chk(reg_rdata[24] == 1'b1 && reg_rdata[19:16] == 4'd0, "R5 release readback",
        reg_rdata[24:16], 9'h100);
    for (int k = 0; k < 20 && !hit; k++) begin
      if (sync_pt) begin
        hit = 1'b1;
        chk(bank_sw == arm, "R6 strobed set", bank_sw, arm);
      end else begin
        if (bank_sw != 4'd0) bad++;
        @(negedge clk);
      end
    end
    chk(hit, "R6 sync reached", hit, 1);
    chk(bad == 0, "R10 no early strobe", bad, 0);
    @(negedge clk);
    chk(reg_rdata[24] == 1'b0 && bank_sw == 4'd0, "R7 release cleared",
        {reg_rdata[24], bank_sw}, 0);
  endtask

  task automatic t_handshake();
    link_active = '0;
    wr(PER9 | 32'h0000_8000);
    chk(reg_rdata[15] == 1'b1, "R9 handshake set", reg_rdata[15], 1);
    wait_sync();
    wait_sync();
    @(negedge clk);
    chk(reg_rdata[15] == 1'b1, "R9 held while idle", reg_rdata[15], 1);
    wr(PER9);
    chk(reg_rdata[15] == 1'b1, "R9 write 0 ignored", reg_rdata[15], 1);
    wait_sync();
    repeat (2) @(negedge clk);
    link_active = 4'b0100;
    @(negedge clk);
    link_active = 4'b0000;
    chk(reg_rdata[15] == 1'b1, "R8 not before sync", reg_rdata[15], 1);
    wait_sync();
    @(negedge clk);
    chk(reg_rdata[15] == 1'b0, "R8 cleared at sync", reg_rdata[15], 0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    cyc = 0;
    done = 1'b0;
    t_reset();
    t_default_period();
    t_period_change();
    t_fields();
    t_release(4'b0101);
    t_release(4'b1111);
    t_release(4'b0010);
    t_release(4'b0000);
    t_handshake();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule